// File: doc/BRIEF.md
# Toggle-on-write interrupt status controller

This block gathers the interrupt causes of a serial peripheral into one 32-bit status word and turns them into a single level interrupt line. Hardware events from the transfer engine and the receive and transmit queues set status bits. Software changes the word by writing a mask that is XORed into it, so every written one inverts the matching bit and every written zero leaves it alone.

A per-bit enable word selects which status bits may raise the line, and a separate global word gates the whole output through its top bit. The output is registered. It is high one clock after the status, enable and global words together call for it. Two queue conditions are levels, not pulses: while the receive queue holds data, or while it is full, the matching status bit is forced to one on every clock. A software toggle cannot clear such a bit while its condition holds.

Top module: `irq_toggle_ctrl`

## Requirements
- R1: After reset the status, enable and global words all read as zero and `irq` is low.
- R2: A write to byte offset 0x20 replaces the status word with the old status XOR `reg_wdata`, and a read at 0x20 returns the status word.
- R3: A write to byte offset 0x28 loads the enable word, and a read at 0x28 returns it unchanged.
- R4: A write to byte offset 0x1C keeps only bit 31 of `reg_wdata`. A read at 0x1C returns that bit in position 31, with zeros in every other position.
- R5: `irq` is a register. After the clock edge that loads the words, it equals (status AND enable is nonzero) AND global bit 31, so it changes one cycle after any of those words changes.
- R6: A one-cycle `xfer_byte` pulse sets status bit 2 (transmit empty) and status bit 8 (receive data available).
- R7: A one-cycle `xfer_lost` pulse sets status bit 5 (receive overrun).
- R8: While `rxq_nonempty` is high, status bit 8 is set on every clock, so a toggle write cannot clear it. Once the input falls, a toggle clears it.
- R9: While `rxq_full` is high, status bit 4 is set on every clock, with the same effect on toggle writes as in R8.
- R10: Each high bit of `evt_set` sets the status bit of the same index. The transmit half-empty cause uses bit 6 and the transmit underrun cause uses bit 3.
- R11: When a hardware set and a toggle write hit the same status bit in one cycle, the bit ends at 1, whatever its prior value.
- R12: Writes to any other offset change none of the three words. Reads at any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_set | input | 32 | Per-bit hardware set pulses into the status word |
| xfer_byte | input | 1 | Pulse: one byte moved out and one byte came in |
| xfer_lost | input | 1 | Pulse: a received byte was dropped because the queue was full |
| rxq_nonempty | input | 1 | Level: receive queue holds data |
| rxq_full | input | 1 | Level: receive queue is full |
| irq | output | 1 | Registered level interrupt |

## Verification
The bound checker watches on every cycle that the output follows the previous cycle's status, enable and global words. It also checks that each hardware cause leaves its bit set on the next edge, that a lone toggle write gives exactly the XOR, and that with no write and no event the status does not move. These checks cover the set-wins rule, the level reassertion and the gating by bit 31 in any order of traffic. What only the bench can show are the values seen at the read port: the reset contents, the masking of the global word to one bit, zeros from unmapped offsets, and the full sweep of enable bit against status bit with the global gate both off and on.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  // Byte offsets of the three words
  localparam int OFS_GLOBAL = 'h1C;
  localparam int OFS_STATUS = 'h20;
  localparam int OFS_ENABLE = 'h28;

  // Status bit positions used by the named causes
  localparam int BIT_RX_AVAIL = 8;
  localparam int BIT_TX_HALF  = 6;
  localparam int BIT_RX_OVR   = 5;
  localparam int BIT_RX_FULL  = 4;
  localparam int BIT_TX_UNDER = 3;
  localparam int BIT_TX_EMPTY = 2;

  typedef struct packed {
    logic glb;
    logic stat;
    logic ena;
  } word_sel_t;
endpackage

// File: rtl/irqt_rst_sync.sv
module irqt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/irqt_evt_merge.sv
module irqt_evt_merge
  import irqt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] evt_set,
  input  logic              xfer_byte,
  input  logic              xfer_lost,
  input  logic              rxq_nonempty,
  input  logic              rxq_full,
  output logic [DATA_W-1:0] hw_set
);
  // Combine pulse and level causes into one set vector
  always_comb begin
    hw_set = evt_set;
    if (xfer_byte) begin
      hw_set[BIT_TX_EMPTY] = 1'b1;
      hw_set[BIT_RX_AVAIL] = 1'b1;
    end
    if (xfer_lost)    hw_set[BIT_RX_OVR]   = 1'b1;
    if (rxq_nonempty) hw_set[BIT_RX_AVAIL] = 1'b1;
    if (rxq_full)     hw_set[BIT_RX_FULL]  = 1'b1;
  end
endmodule

// File: rtl/irqt_regfile.sv
module irqt_regfile
  import irqt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] ena_q,
  output logic              glb_q
);
  localparam int GLB_BIT = DATA_W - 1;

  word_sel_t         sel;
  logic [DATA_W-1:0] stat_d;
  logic              stat_ce;
  logic              ena_ce;
  logic              glb_ce;

  // Address decode
  always_comb begin
    sel.glb  = (addr == ADDR_W'(OFS_GLOBAL));
    sel.stat = (addr == ADDR_W'(OFS_STATUS));
    sel.ena  = (addr == ADDR_W'(OFS_ENABLE));
  end

  // Next state: toggle first, then hardware set on top so it wins
  always_comb begin
    stat_d = stat_q;
    if (wr_en && sel.stat) stat_d = stat_q ^ wdata;
    stat_d  = stat_d | hw_set;
    stat_ce = (wr_en && sel.stat) || (|hw_set);
    ena_ce  = wr_en && sel.ena;
    glb_ce  = wr_en && sel.glb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ena_q  <= '0;
      glb_q  <= 1'b0;
    end else begin
      if (stat_ce) stat_q <= stat_d;
      if (ena_ce)  ena_q  <= wdata;
      if (glb_ce)  glb_q  <= wdata[GLB_BIT];
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    unique case (1'b1)
      sel.glb:  rdata[GLB_BIT] = glb_q;
      sel.stat: rdata = stat_q;
      sel.ena:  rdata = ena_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqt_out.sv
module irqt_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] ena_q,
  input  logic              glb_q,
  output logic              irq
);
  logic irq_d;
  logic irq_q;

  always_comb irq_d = (|(stat_q & ena_q)) && glb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_toggle_ctrl.sv
module irq_toggle_ctrl #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] evt_set,
  input  logic              xfer_byte,
  input  logic              xfer_lost,
  input  logic              rxq_nonempty,
  input  logic              rxq_full,
  output logic              irq
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] hw_set;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] ena_q;
  logic              glb_q;

  irqt_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  irqt_evt_merge #(.DATA_W(DATA_W)) u_merge (
    .evt_set      (evt_set),
    .xfer_byte    (xfer_byte),
    .xfer_lost    (xfer_lost),
    .rxq_nonempty (rxq_nonempty),
    .rxq_full     (rxq_full),
    .hw_set       (hw_set)
  );

  irqt_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .hw_set (hw_set),
    .rdata  (reg_rdata),
    .stat_q (stat_q),
    .ena_q  (ena_q),
    .glb_q  (glb_q)
  );

  irqt_out #(.DATA_W(DATA_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .stat_q (stat_q),
    .ena_q  (ena_q),
    .glb_q  (glb_q),
    .irq    (irq)
  );
endmodule

// File: rtl/irq_toggle_ctrl_chk.sv
module irq_toggle_ctrl_chk
  import irqt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] evt_set,
  input logic              xfer_byte,
  input logic              xfer_lost,
  input logic              rxq_nonempty,
  input logic              rxq_full,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] ena_q,
  input logic              glb_q,
  input logic              irq
);
  logic past_valid;
  logic no_hw;
  logic stat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  always_comb begin
    no_hw   = !(|evt_set) && !xfer_byte && !xfer_lost && !rxq_nonempty && !rxq_full;
    stat_wr = wr_en && (addr == ADDR_W'(OFS_STATUS));
  end

  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> (irq == ($past(|(stat_q & ena_q)) && $past(glb_q)))); // R5
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !$past(glb_q)) |-> !irq); // R4
  AST_XFER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_byte |=> (stat_q[BIT_TX_EMPTY] && stat_q[BIT_RX_AVAIL])); // R6
  AST_LOST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_lost |=> stat_q[BIT_RX_OVR]); // R7
  AST_AVAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_nonempty |=> stat_q[BIT_RX_AVAIL]); // R8
  AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_full |=> stat_q[BIT_RX_FULL]); // R9
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((stat_q & $past(evt_set)) == $past(evt_set))); // R10 R11
  AST_TOGGLE_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && no_hw) |=> (stat_q == ($past(stat_q) ^ $past(wdata)))); // R2
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && no_hw) |=> $stable(stat_q)); // R12
endmodule

bind irq_toggle_ctrl irq_toggle_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .wr_en        (reg_wr),
  .addr         (reg_addr),
  .wdata        (reg_wdata),
  .evt_set      (evt_set),
  .xfer_byte    (xfer_byte),
  .xfer_lost    (xfer_lost),
  .rxq_nonempty (rxq_nonempty),
  .rxq_full     (rxq_full),
  .stat_q       (stat_q),
  .ena_q        (ena_q),
  .glb_q        (glb_q),
  .irq          (irq)
);

// File: tb/irq_toggle_ctrl_bench.sv
`timescale 1ns/1ps
module irq_toggle_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [31:0] evt;
  logic        xb, xl, ne, fl;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  irq_toggle_ctrl u_irq_toggle_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (wr),
    .reg_addr     (addr),
    .reg_wdata    (wdata),
    .reg_rdata    (rdata),
    .evt_set      (evt),
    .xfer_byte    (xb),
    .xfer_lost    (xl),
    .rxq_nonempty (ne),
    .rxq_full     (fl),
    .irq          (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference words derived from the requirements
  logic [31:0] m_stat, m_en;
  logic        m_gie;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat <= '0; m_en <= '0; m_gie <= 1'b0;
    end else begin
      m_stat <= (((wr && addr == 8'h20) ? (m_stat ^ wdata) : m_stat) | evt
                 | (xb ? 32'h0000_0104 : 32'h0) | (xl ? 32'h0000_0020 : 32'h0)
                 | (ne ? 32'h0000_0100 : 32'h0) | (fl ? 32'h0000_0010 : 32'h0));
      if (wr && addr == 8'h28) m_en  <= wdata;
      if (wr && addr == 8'h1C) m_gie <= wdata[31];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic clear_status();
    wr_reg(8'h20, m_stat);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0; evt = '0;
    xb = 1'b0; xl = 1'b0; ne = 1'b0; fl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset contents
    rd_chk("R1 status", 8'h20, 32'h0);
    rd_chk("R1 enable", 8'h28, 32'h0);
    rd_chk("R1 global", 8'h1C, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 toggle sweep over each bit, then a mixed pattern
    for (int i = 0; i < 32; i++) begin
      wr_reg(8'h20, 32'h1 << i);
      rd_chk("R2 toggle on", 8'h20, 32'h1 << i);
      wr_reg(8'h20, 32'h1 << i);
      rd_chk("R2 toggle off", 8'h20, 32'h0);
    end
    wr_reg(8'h20, 32'hA5A5_5A5A);
    wr_reg(8'h20, 32'hFFFF_0000);
    rd_chk("R2 double toggle", 8'h20, 32'h5A5A_5A5A);
    clear_status();
    rd_chk("R2 cleared", 8'h20, 32'h0);

    // R3 enable load and read back
    wr_reg(8'h28, 32'hDEAD_BEEF);
    rd_chk("R3 enable", 8'h28, 32'hDEAD_BEEF);
    wr_reg(8'h28, 32'h1234_5678);
    rd_chk("R3 enable", 8'h28, 32'h1234_5678);

    // R4 global word keeps bit 31 only
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    rd_chk("R4 global set", 8'h1C, 32'h8000_0000);
    wr_reg(8'h1C, 32'h7FFF_FFFF);
    rd_chk("R4 global clear", 8'h1C, 32'h0);

    // R5 sweep: global x enable bit x status bit
    for (int g = 0; g < 2; g++) begin
      wr_reg(8'h1C, g[0] ? 32'h8000_0000 : 32'h0);
      for (int i = 0; i < 32; i++) begin
        wr_reg(8'h28, 32'h1 << i);
        for (int j = 0; j < 32; j++) begin
          wr_reg(8'h20, 32'h1 << j);
          // status loaded at the last edge; irq follows at the next one
          chk("R5 irq not early", {31'b0, irq}, 32'h0);
          @(negedge clk);
          chk("R5 irq", {31'b0, irq}, {31'b0, (g == 1) && (i == j)});
          wr_reg(8'h20, 32'h1 << j);
          @(negedge clk);
          chk("R5 irq drop", {31'b0, irq}, 32'h0);
        end
      end
    end
    wr_reg(8'h1C, 32'h0);
    wr_reg(8'h28, 32'h0);

    // R6 transfer pulse
    xb = 1'b1; @(negedge clk); xb = 1'b0;
    rd_chk("R6 transfer", 8'h20, 32'h0000_0104);
    clear_status();

    // R7 lost byte
    xl = 1'b1; @(negedge clk); xl = 1'b0;
    rd_chk("R7 overrun", 8'h20, 32'h0000_0020);
    clear_status();

    // R8 receive-available level
    ne = 1'b1; @(negedge clk);
    rd_chk("R8 level set", 8'h20, 32'h0000_0100);
    wr_reg(8'h20, 32'h0000_0100);
    rd_chk("R8 toggle blocked", 8'h20, 32'h0000_0100);
    ne = 1'b0;
    wr_reg(8'h20, 32'h0000_0100);
    rd_chk("R8 toggle after release", 8'h20, 32'h0);

    // R9 receive-full level
    fl = 1'b1; @(negedge clk);
    wr_reg(8'h20, 32'h0000_0010);
    rd_chk("R9 toggle blocked", 8'h20, 32'h0000_0010);
    fl = 1'b0;
    wr_reg(8'h20, 32'h0000_0010);
    rd_chk("R9 toggle after release", 8'h20, 32'h0);

    // R10 each event bit
    for (int i = 0; i < 32; i++) begin
      evt = 32'h1 << i; @(negedge clk); evt = '0;
      rd_chk("R10 event bit", 8'h20, 32'h1 << i);
      clear_status();
    end
    evt = 32'h0000_0048; @(negedge clk); evt = '0;
    rd_chk("R10 half-empty and underrun", 8'h20, 32'h0000_0048);
    clear_status();

    // R11 set wins against toggle, from 1 and from 0
    wr_reg(8'h20, 32'h0000_0008);
    evt = 32'h0000_0008; wr_reg(8'h20, 32'h0000_0008); evt = '0;
    rd_chk("R11 set wins from one", 8'h20, 32'h0000_0008);
    clear_status();
    evt = 32'h0000_0040; wr_reg(8'h20, 32'h0000_0040); evt = '0;
    rd_chk("R11 set wins from zero", 8'h20, 32'h0000_0040);
    clear_status();

    // R12 unmapped offsets
    wr_reg(8'h20, 32'h0F0F_0F0F);
    wr_reg(8'h28, 32'h3333_3333);
    wr_reg(8'h1C, 32'h8000_0000);
    wr_reg(8'h24, 32'hFFFF_FFFF);
    wr_reg(8'h00, 32'hFFFF_FFFF);
    wr_reg(8'h2C, 32'hFFFF_FFFF);
    wr_reg(8'h18, 32'h0000_0000);
    rd_chk("R12 unmapped read", 8'h24, 32'h0);
    rd_chk("R12 unmapped read", 8'h40, 32'h0);
    rd_chk("R12 status kept", 8'h20, 32'h0F0F_0F0F);
    rd_chk("R12 enable kept", 8'h28, 32'h3333_3333);
    rd_chk("R12 global kept", 8'h1C, 32'h8000_0000);
    @(negedge clk);
    chk("R5 irq with live words", {31'b0, irq}, {31'b0, m_gie && |(m_stat & m_en)});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule